// File: doc/BRIEF.md
# Six-Channel Asynchronous Memory Bus Sequencer

The block turns single 32-bit requests from an on-chip master into timed strobe sequences for slow asynchronous parts: ROM, SRAM, flash and memory-mapped peripherals. Six chip-enable outputs each belong to one channel. Every channel has its own static configuration word. The word sets the device data width, the bus-clock divisor, the byte-lane style, the choice between a fixed wait count and an external ready handshake, and four programmable setup and hold intervals around the strobes.

A master sets `req_valid` for a cycle while the block is idle. With it the master gives a one-hot channel hit, a word address, the write data, a byte mask and the direction. The block then drives one, two or four external beats, depending on the width. It raises `rsp_done` for one cycle when the last beat has finished. For reads, `rsp_rdata` holds the assembled word in that cycle. All external strobes are active low and rest high. The write-data drivers are enabled only while the write strobe is low.

Top module: `ebc_top`

## Requirements
- R1: After reset, every chip enable, `ext_oe_n`, `ext_we_n` and all four lanes of `ext_be_n` are high, `ext_dq_oe` is 0 and `rsp_done` is 0.
- R2: `req_cs` is one-hot and bit i selects channel i; if several bits are set, the lowest wins. Only `ext_ce_n[i]` of the selected channel ever goes low. A request with `req_cs` all zero is dropped: no strobe moves and `rsp_done` stays low.
- R3: Channel word bits [1:0] select the width: 0 = 32 bits, 1 = 16 bits, 2 or 3 = 8 bits. This gives 1, 2 or 4 beats. `ext_addr` is a byte address equal to `{req_waddr,2'b00}` plus beat×(4/beats). Lanes that the width does not use stay high: lanes 3:2 for 16 bits, lanes 3:1 for 8 bits.
- R4: Lane k carries data bits 8k+7:8k. For a write, beat b drives the whole word at 32 bits, `req_wdata[16b+15:16b]` on bits 15:0 at 16 bits, and `req_wdata[8b+7:8b]` on bits 7:0 at 8 bits. Beat b uses the matching bits of `req_be`, where bit j of `req_be` enables byte j.
- R5: Read beats are packed little-endian. Beat b fills `rsp_rdata` bits 16b+15:16b at 16 bits and bits 8b+7:8b at 8 bits. The data is sampled at the clock edge that ends the strobe, and it is valid while `rsp_done` is high.
- R6: Word bits [3:2] = d set the divisor N = d+1. A tick is N clocks long, and every interval below is counted in ticks. For N > 1, `ext_sysclk` is high for the first (N+1)/2 clocks of each tick and low for the rest. Tick phase is restarted when a request is accepted. For N = 1, `ext_sysclk` follows the clock.
- R7: Each beat runs through five intervals in order. Address setup lasts [11:10] ticks with the chip enable high. Enable setup lasts [13:12] ticks with the chip enable low. The strobe follows. Strobe hold lasts [15:14] ticks with the chip enable still low. Address hold lasts [17:16] ticks with the chip enable high. A zero count skips its interval.
- R8: When word bit 5 is 0, the strobe is low for [9:6]+1 ticks. With request acceptance at edge E, `rsp_done` is high exactly in the clock that starts at E + beats×(sum of the five interval lengths)×N.
- R9: When word bit 5 is 1, the strobe ends at the first tick boundary at which `ext_ack_n` is low, and it lasts at least one tick.
- R10: When word bit 4 is 0, the lanes are asserted (low, per mask) through enable setup, strobe and strobe hold, on reads and on writes. When bit 4 is 1, they are asserted only while the write strobe is low, and never on reads.
- R11: `ext_oe_n` is low only during a read strobe and `ext_we_n` only during a write strobe. `ext_dq_oe` is 1 exactly while `ext_we_n` is low.
- R12: `rsp_done` is a single-cycle pulse, one per accepted request, and after it the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_flat | input | NCH*18 | Channel words; channel i occupies bits 18i+17:18i |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | NCH | One-hot channel hit |
| req_waddr | input | AW-2 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte mask, bit j = byte j |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Assembled read word |
| ext_sysclk | output | 1 | External bus clock |
| ext_addr | output | AW | External byte address |
| ext_dq_out | output | 32 | Data to drive on the external bus |
| ext_dq_oe | output | 1 | Output enable of the data drivers |
| ext_dq_in | input | 32 | Data seen on the external bus |
| ext_ce_n | output | NCH | Chip enables, active low |
| ext_oe_n | output | 1 | Output enable strobe, active low |
| ext_we_n | output | 1 | Write strobe, active low |
| ext_be_n | output | 4 | Byte-lane strobes, active low |
| ext_ack_n | input | 1 | Ready/acknowledge, active low |

## Verification
The assertions check four properties on every cycle. At most one chip enable is low. Read and write strobes never overlap, and neither appears outside a chip-enable window. The data drivers are on only under the write strobe. Unused lanes stay high, a read in write-enable lane style leaves the lanes idle, and a pending ready keeps the strobe held. Other behaviour depends on sequences, and only the bench scenarios can show it: the exact tick count of each interval under every divisor, ascending beat addresses, the steering of write data per beat, little-endian read assembly and the completion cycle. The bench compares the expected strobe waveform clock by clock.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    localparam int LANES = 4;
    localparam int DW    = 8 * LANES;

    // channel configuration word, LSB field last in this list
    typedef struct packed {
        logic [1:0] t_ah;      // address hold ticks
        logic [1:0] t_ch;      // strobe hold ticks (enable still low)
        logic [1:0] t_cs;      // enable-to-strobe ticks
        logic [1:0] t_as;      // address setup ticks
        logic [3:0] wait_n;    // strobe width - 1 when handshake off
        logic       rdy_en;    // strobe ends on ready
        logic       bwe_style; // lanes only under write strobe
        logic [1:0] div;       // tick = div+1 clocks
        logic [1:0] width;     // 0:32 1:16 else 8
    } chcfg_t;

    localparam int CFGW = $bits(chcfg_t);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ASU,
        PH_CSU,
        PH_STB,
        PH_CHD,
        PH_AHD,
        PH_DONE
    } phase_e;

    function automatic logic [1:0] last_beat(input logic [1:0] w);
        case (w)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    // first interval after p with a non-zero length; PH_IDLE = beat over
    function automatic phase_e next_ph(input phase_e p, input chcfg_t c);
        case (p)
            PH_IDLE: return (c.t_as != 2'd0) ? PH_ASU :
                            (c.t_cs != 2'd0) ? PH_CSU : PH_STB;
            PH_ASU:  return (c.t_cs != 2'd0) ? PH_CSU : PH_STB;
            PH_CSU:  return PH_STB;
            PH_STB:  return (c.t_ch != 2'd0) ? PH_CHD :
                            (c.t_ah != 2'd0) ? PH_AHD : PH_IDLE;
            PH_CHD:  return (c.t_ah != 2'd0) ? PH_AHD : PH_IDLE;
            default: return PH_IDLE;
        endcase
    endfunction

    // interval length in ticks minus one
    function automatic logic [3:0] len_m1(input phase_e p, input chcfg_t c);
        case (p)
            PH_ASU:  return {2'b00, c.t_as} - 4'd1;
            PH_CSU:  return {2'b00, c.t_cs} - 4'd1;
            PH_STB:  return c.wait_n;
            PH_CHD:  return {2'b00, c.t_ch} - 4'd1;
            PH_AHD:  return {2'b00, c.t_ah} - 4'd1;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/ebc_chsel.sv
module ebc_chsel
    import ebc_pkg::*;
#(
    parameter int NCH = 6,
    parameter int IW  = $clog2(NCH)
) (
    input  logic [NCH*CFGW-1:0] cfg_flat,
    input  logic [NCH-1:0]      hit,
    output chcfg_t              sel_cfg,
    output logic [IW-1:0]       sel_idx,
    output logic                sel_any
);

    chcfg_t cfg_arr [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign cfg_arr[g] = chcfg_t'(cfg_flat[g*CFGW +: CFGW]);
    end

    // lowest set hit bit wins
    always_comb begin
        sel_cfg = '0;
        sel_idx = '0;
        sel_any = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_cfg = cfg_arr[i];
                sel_idx = IW'(i);
                sel_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ebc_clkdiv.sv
module ebc_clkdiv (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] div,
    output logic       tick,
    output logic       sysclk
);

    typedef struct packed {
        logic [1:0] cnt;
        logic       sclk;
    } dv_t;

    dv_t dv_d, dv_q;

    always_comb begin
        dv_d = dv_q;
        if (restart || dv_q.cnt == div) begin
            dv_d.cnt = 2'd0;
        end else begin
            dv_d.cnt = dv_q.cnt + 2'd1;
        end
        dv_d.sclk = (dv_d.cnt <= (div >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q <= '{cnt: 2'd0, sclk: 1'b1};
        end else begin
            dv_q <= dv_d;
        end
    end

    assign tick   = (dv_q.cnt == div);
    assign sysclk = (div == 2'd0) ? clk : dv_q.sclk;

    // R6: a tick always wraps the phase counter back to zero
    assert_tick_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (dv_q.cnt == 2'd0));

endmodule

// File: rtl/ebc_lanes.sv
module ebc_lanes (
    input  logic [1:0]  width,
    input  logic [1:0]  beat,
    input  logic [31:0] wdata,
    input  logic [3:0]  be,
    input  logic [31:0] dq_in,
    input  logic [31:0] rdata_acc,
    output logic [3:0]  mask,
    output logic [31:0] dq_out,
    output logic [31:0] rdata_nxt,
    output logic [1:0]  offset
);

    logic [4:0] sh16;
    logic [4:0] sh8;

    assign sh16 = {beat[0], 4'b0000};
    assign sh8  = {beat, 3'b000};

    always_comb begin
        rdata_nxt = rdata_acc;
        case (width)
            2'd0: begin
                mask      = be;
                dq_out    = wdata;
                rdata_nxt = dq_in;
                offset    = 2'd0;
            end
            2'd1: begin
                mask   = {2'b00, be[{beat[0], 1'b0} +: 2]};
                dq_out = {16'h0000, wdata[sh16 +: 16]};
                rdata_nxt[sh16 +: 16] = dq_in[15:0];
                offset = {beat[0], 1'b0};
            end
            default: begin
                mask   = {3'b000, be[beat]};
                dq_out = {24'h000000, wdata[sh8 +: 8]};
                rdata_nxt[sh8 +: 8] = dq_in[7:0];
                offset = beat;
            end
        endcase
    end

endmodule

// File: rtl/ebc_top.sv
module ebc_top
    import ebc_pkg::*;
#(
    parameter int NCH = 6,
    parameter int AW  = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH*CFGW-1:0] cfg_flat,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [NCH-1:0]      req_cs,
    input  logic [AW-3:0]       req_waddr,
    input  logic [31:0]         req_wdata,
    input  logic [3:0]          req_be,
    output logic                rsp_done,
    output logic [31:0]         rsp_rdata,
    output logic                ext_sysclk,
    output logic [AW-1:0]       ext_addr,
    output logic [31:0]         ext_dq_out,
    output logic                ext_dq_oe,
    input  logic [31:0]         ext_dq_in,
    output logic [NCH-1:0]      ext_ce_n,
    output logic                ext_oe_n,
    output logic                ext_we_n,
    output logic [3:0]          ext_be_n,
    input  logic                ext_ack_n
);

    localparam int IW = $clog2(NCH);

    typedef struct packed {
        phase_e        phase;
        logic [IW-1:0] ch;
        chcfg_t        cfg;
        logic          wr;
        logic [AW-3:0] waddr;
        logic [31:0]   wdata;
        logic [3:0]    be;
        logic [1:0]    beat;
        logic [3:0]    cnt;
        logic [31:0]   rdata;
    } st_t;

    st_t st_d, st_q;

    chcfg_t        sel_cfg;
    logic [IW-1:0] sel_idx;
    logic          sel_any;
    logic          accept;
    logic          tick;
    logic [3:0]    lane_mask;
    logic [31:0]   lane_dout;
    logic [31:0]   rdata_nxt;
    logic [1:0]    beat_off;
    logic          ce_win;
    logic          lanes_on;

    ebc_chsel #(.NCH(NCH), .IW(IW)) u_chsel (
        .cfg_flat (cfg_flat),
        .hit      (req_cs),
        .sel_cfg  (sel_cfg),
        .sel_idx  (sel_idx),
        .sel_any  (sel_any)
    );

    ebc_clkdiv u_clkdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .div     (st_q.cfg.div),
        .tick    (tick),
        .sysclk  (ext_sysclk)
    );

    ebc_lanes u_lanes (
        .width     (st_q.cfg.width),
        .beat      (st_q.beat),
        .wdata     (st_q.wdata),
        .be        (st_q.be),
        .dq_in     (ext_dq_in),
        .rdata_acc (st_q.rdata),
        .mask      (lane_mask),
        .dq_out    (lane_dout),
        .rdata_nxt (rdata_nxt),
        .offset    (beat_off)
    );

    // next-state computation
    always_comb begin
        phase_e nxt;
        logic   end_ph;
        st_d   = st_q;
        accept = 1'b0;
        nxt    = PH_IDLE;
        end_ph = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid && sel_any) begin
                    accept      = 1'b1;
                    st_d.ch     = sel_idx;
                    st_d.cfg    = sel_cfg;
                    st_d.wr     = req_write;
                    st_d.waddr  = req_waddr;
                    st_d.wdata  = req_wdata;
                    st_d.be     = req_be;
                    st_d.beat   = 2'd0;
                    st_d.rdata  = '0;
                    nxt         = next_ph(PH_IDLE, sel_cfg);
                    st_d.phase  = nxt;
                    st_d.cnt    = len_m1(nxt, sel_cfg);
                end
            end
            PH_DONE: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                if (tick) begin
                    if (st_q.phase == PH_STB && st_q.cfg.rdy_en) begin
                        end_ph = !ext_ack_n;
                    end else begin
                        end_ph = (st_q.cnt == 4'd0);
                    end
                    if (st_q.phase == PH_STB && end_ph && !st_q.wr) begin
                        st_d.rdata = rdata_nxt;
                    end
                    if (!end_ph) begin
                        if (st_q.cnt != 4'd0) begin
                            st_d.cnt = st_q.cnt - 4'd1;
                        end
                    end else begin
                        nxt = next_ph(st_q.phase, st_q.cfg);
                        if (nxt == PH_IDLE) begin
                            if (st_q.beat == last_beat(st_q.cfg.width)) begin
                                st_d.phase = PH_DONE;
                            end else begin
                                st_d.beat  = st_q.beat + 2'd1;
                                nxt        = next_ph(PH_IDLE, st_q.cfg);
                                st_d.phase = nxt;
                                st_d.cnt   = len_m1(nxt, st_q.cfg);
                            end
                        end else begin
                            st_d.phase = nxt;
                            st_d.cnt   = len_m1(nxt, st_q.cfg);
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // output decode
    assign ce_win   = (st_q.phase == PH_CSU) || (st_q.phase == PH_STB) ||
                      (st_q.phase == PH_CHD);
    assign lanes_on = st_q.cfg.bwe_style ? (st_q.phase == PH_STB && st_q.wr) : ce_win;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ext_ce_n[i] = !(ce_win && (st_q.ch == IW'(i)));
        end
    end

    assign ext_oe_n   = !(st_q.phase == PH_STB && !st_q.wr);
    assign ext_we_n   = !(st_q.phase == PH_STB && st_q.wr);
    assign ext_be_n   = lanes_on ? ~lane_mask : 4'hF;
    assign ext_dq_oe  = (st_q.phase == PH_STB) && st_q.wr;
    assign ext_dq_out = lane_dout;
    assign ext_addr   = {st_q.waddr, 2'b00} | {{(AW-2){1'b0}}, beat_off};
    assign rsp_done   = (st_q.phase == PH_DONE);
    assign rsp_rdata  = st_q.rdata;

    // R2: never more than one chip enable low
    assert_ce_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_ce_n));

    // R2: a request without a channel hit leaves the block idle
    assert_nohit_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !sel_any) |=> (st_q.phase == PH_IDLE));

    // R3: lanes beyond the device width stay high
    assert_unused_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.width != 2'd0) |-> (ext_be_n[3:2] == 2'b11));

    // R7: strobes only inside a chip-enable window
    assert_strobe_in_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_oe_n || !ext_we_n) |-> (ext_ce_n != {NCH{1'b1}}));

    // R9: pending ready keeps the strobe held
    assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_STB && st_q.cfg.rdy_en && ext_ack_n) |=> (st_q.phase == PH_STB));

    // R10: write-enable lane style leaves lanes idle during reads
    assert_bwe_read_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.bwe_style && !ext_oe_n) |-> (ext_be_n == 4'hF));

    // R11: read and write strobes never overlap; drivers only under write strobe
    assert_oe_we_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_oe_n && !ext_we_n));
    assert_dq_under_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dq_oe |-> !ext_we_n);

    // R12: completion is a one-cycle pulse
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/ebc_top_tb.sv
module ebc_top_tb;

    localparam int NCH = 6;
    localparam int AW  = 20;
    localparam int CW  = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*CW-1:0] cfg_flat = '0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [NCH-1:0]    req_cs = '0;
    logic [AW-3:0]     req_waddr = '0;
    logic [31:0]       req_wdata = '0;
    logic [3:0]        req_be = '0;
    logic              rsp_done;
    logic [31:0]       rsp_rdata;
    logic              ext_sysclk;
    logic [AW-1:0]     ext_addr;
    logic [31:0]       ext_dq_out;
    logic              ext_dq_oe;
    logic [31:0]       ext_dq_in;
    logic [NCH-1:0]    ext_ce_n;
    logic              ext_oe_n;
    logic              ext_we_n;
    logic [3:0]        ext_be_n;
    logic              ext_ack_n = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ebc_top #(.NCH(NCH), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_waddr(req_waddr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ext_sysclk(ext_sysclk),
        .ext_addr(ext_addr), .ext_dq_out(ext_dq_out), .ext_dq_oe(ext_dq_oe),
        .ext_dq_in(ext_dq_in), .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n),
        .ext_we_n(ext_we_n), .ext_be_n(ext_be_n), .ext_ack_n(ext_ack_n)
    );

    // byte-addressed memory pattern seen by reads
    function automatic logic [7:0] mb(input logic [AW-1:0] a);
        return a[7:0] * 8'd7 + a[15:8] + 8'h3d;
    endfunction

    assign ext_dq_in = {mb(ext_addr + 20'd3), mb(ext_addr + 20'd2),
                        mb(ext_addr + 20'd1), mb(ext_addr)};

    function automatic logic [CW-1:0] mkcfg(input int width, input int div, input bit bwe,
                                            input bit rdy, input int wt, input int tas,
                                            input int tcs, input int tch, input int tah);
        logic [CW-1:0] c;
        c[1:0]   = 2'(width);
        c[3:2]   = 2'(div);
        c[4]     = bwe;
        c[5]     = rdy;
        c[9:6]   = 4'(wt);
        c[11:10] = 2'(tas);
        c[13:12] = 2'(tcs);
        c[15:14] = 2'(tch);
        c[17:16] = 2'(tah);
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one access, compared clock by clock against a model of the requirements
    task automatic do_access(input int ch, input logic [CW-1:0] cw, input bit wr,
                             input logic [AW-3:0] wa, input logic [31:0] wd,
                             input logic [3:0] be);
        int width = int'(cw[1:0]);
        int n     = int'(cw[3:2]) + 1;
        bit bwe   = cw[4];
        int wt    = int'(cw[9:6]);
        int tas   = int'(cw[11:10]);
        int tcs   = int'(cw[13:12]);
        int tch   = int'(cw[15:14]);
        int tah   = int'(cw[17:16]);
        int beats = (width == 0) ? 1 : (width == 1) ? 2 : 4;
        int bpb   = 4 / beats;
        int per   = tas + tcs + wt + 1 + tch + tah;
        int tot   = beats * per * n;
        int m_ce = 0, m_str = 0, m_lane = 0, m_addr = 0, m_dat = 0, m_clk = 0, m_done = 0;
        logic [31:0] rd = '0;
        logic [31:0] exp_rd;
        logic [AW-1:0] base;
        base   = {wa, 2'b00};
        exp_rd = {mb(base + 20'd3), mb(base + 20'd2), mb(base + 20'd1), mb(base)};
        cfg_flat[ch*CW +: CW] = cw;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cs = NCH'(1) << ch;
        req_waddr = wa; req_wdata = wd; req_be = be;
        @(posedge clk);
        for (int c = 0; c <= tot + 1; c++) begin
            int k, b, w, ph;
            logic [NCH-1:0] e_ce;
            logic [3:0] msk, e_be;
            bit lon;
            @(negedge clk);
            if (c == 0) begin
                req_valid = 1'b0;
                req_cs = '0;
            end
            k = c / n; b = k / per; w = k % per;
            if (b >= beats)                    ph = 0;
            else if (w < tas)                  ph = 1;
            else if (w < tas + tcs)            ph = 2;
            else if (w < tas + tcs + wt + 1)   ph = 3;
            else if (w < tas + tcs + wt + 1 + tch) ph = 4;
            else                               ph = 5;
            e_ce = (ph >= 2 && ph <= 4) ? ~(NCH'(1) << ch) : {NCH{1'b1}};
            if (ext_ce_n !== e_ce) m_ce++;                       // R2, R7, R8
            if (ext_oe_n !== !(ph == 3 && !wr)) m_str++;         // R11
            if (ext_we_n !== !(ph == 3 && wr)) m_str++;
            if (ext_dq_oe !== (ph == 3 && wr)) m_str++;
            if (ph == 0) msk = 4'h0;
            else if (width == 0) msk = be;
            else if (width == 1) msk = {2'b00, be[2*b +: 2]};
            else msk = {3'b000, be[b]};
            lon  = bwe ? (ph == 3 && wr) : (ph >= 2 && ph <= 4);
            e_be = lon ? ~msk : 4'hF;
            if (ext_be_n !== e_be) m_lane++;                     // R3, R10
            if (ph != 0 && ext_addr !== base + AW'(b * bpb)) m_addr++;   // R3
            if (ph == 3 && wr) begin                             // R4
                if (width == 0 && ext_dq_out !== wd) m_dat++;
                if (width == 1 && ext_dq_out[15:0] !== wd[16*b +: 16]) m_dat++;
                if (width >= 2 && ext_dq_out[7:0] !== wd[8*b +: 8]) m_dat++;
            end
            if (n > 1 && ext_sysclk !== ((c % n) < (n + 1) / 2)) m_clk++;   // R6
            if (rsp_done !== (c == tot)) m_done++;               // R8, R12
            if (c == tot) rd = rsp_rdata;
        end
        check(m_ce == 0,   "R7", "chip enable waveform mismatches", m_ce, 0);
        check(m_str == 0,  "R11", "strobe/driver mismatches", m_str, 0);
        check(m_lane == 0, "R10", "lane strobe mismatches", m_lane, 0);
        check(m_addr == 0, "R3", "beat address mismatches", m_addr, 0);
        if (wr) check(m_dat == 0, "R4", "write lane data mismatches", m_dat, 0);
        if (n > 1) check(m_clk == 0, "R6", "bus clock mismatches", m_clk, 0);
        check(m_done == 0, "R8", "completion timing mismatches", m_done, 0);
        if (!wr) check(rd == exp_rd, "R5", "assembled read word", rd, exp_rd);
    endtask

    // ready handshake: ack driven low at the ack_at-th low sample of the strobe
    task automatic ready_access(input int div, input int ack_at, input int exp_low);
        int low = 0;
        int guard = 0;
        cfg_flat[2*CW +: CW] = mkcfg(0, div, 1'b0, 1'b1, 0, 0, 0, 0, 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_cs = 6'b000100;
        req_waddr = 18'h00123; req_wdata = 32'hA5A5_0F0F; req_be = 4'hF;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_cs = '0;
        while (guard < 200 && !rsp_done) begin
            if (!ext_we_n) begin
                low++;
                if (low == ack_at) ext_ack_n = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        ext_ack_n = 1'b1;
        check(low == exp_low, "R9", "strobe length under ready", low, exp_low);
        check(rsp_done == 1'b1, "R12", "done after ready access", {31'd0, rsp_done}, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ext_ce_n == 6'h3F && ext_oe_n && ext_we_n && ext_be_n == 4'hF,
              "R1", "strobes in reset", {ext_ce_n, ext_oe_n, ext_we_n, ext_be_n}, 32'hFFF);
        check(!ext_dq_oe && !rsp_done, "R1", "driver/done in reset",
              {ext_dq_oe, rsp_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ext_ce_n == 6'h3F && ext_oe_n && ext_we_n, "R1", "idle after reset",
              {ext_ce_n, ext_oe_n, ext_we_n}, 32'hFF);

        // R2: request without channel hit is dropped
        begin
            int bad = 0;
            req_valid = 1'b1; req_cs = '0; req_write = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (ext_ce_n != 6'h3F || !ext_we_n || !ext_oe_n || rsp_done) bad++;
            end
            check(bad == 0, "R2", "activity after no-hit request", bad, 0);
        end

        // directed corners
        do_access(0, mkcfg(0, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0), 1'b1, 18'h00010, 32'h1122_3344, 4'hF);
        do_access(0, mkcfg(0, 0, 1'b0, 1'b0, 0, 0, 0, 0, 0), 1'b0, 18'h00011, 32'h0, 4'hF);
        do_access(5, mkcfg(2, 3, 1'b1, 1'b0, 2, 1, 2, 1, 3), 1'b1, 18'h2ABCD, 32'hDEAD_BEEF, 4'b0101);
        do_access(3, mkcfg(1, 2, 1'b0, 1'b0, 15, 3, 3, 3, 3), 1'b0, 18'h3FFFF, 32'h0, 4'b1001);
        do_access(1, mkcfg(3, 1, 1'b0, 1'b0, 1, 0, 1, 0, 1), 1'b0, 18'h00400, 32'h0, 4'hF);
        do_access(4, mkcfg(1, 1, 1'b1, 1'b0, 3, 2, 0, 2, 0), 1'b0, 18'h01234, 32'h0, 4'hF);
        ready_access(0, 3, 3);
        ready_access(1, 3, 4);

        // constrained random mix
        for (int t = 0; t < 70; t++) begin
            logic [CW-1:0] cw;
            cw = CW'($urandom);
            cw[5] = 1'b0;
            do_access(int'($urandom % NCH), cw, 1'($urandom), AW'($urandom) >> 2,
                      $urandom, 4'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule